// File: doc/BRIEF.md
# Host Bus Scratch Memory Slave

This block sits in an FPGA and gives a microcontroller access to a small on-chip word memory over a synchronous parallel bus. The host drives the bus clock, an address, write data and three control strobes: write, read and frame. The block returns read data together with an output-enable. The three-state pad that merges write data and read data onto one shared data bus sits in the pad ring, outside this block.

A write takes one bus clock. The word is stored at the rising edge where write and frame are both high. A read takes two bus clocks. The block registers the address at the first edge and must present the word for that address throughout the second clock, which is when the host samples. The word must never be left over from the previous access. The bus clock only toggles while a transaction is in progress, so no internal state relies on idle clock edges.

Only the low seven address bits select a word. Higher addresses fold back onto the 128 locations.

Top module: `hsb_sram_slave`

## Requirements
- R1: While reset is high at a rising edge, the block clears its read-phase flag and its captured read address. After reset, bus_rdata_oe stays low until a read is presented.
- R2: At a rising edge with bus_wr=1 and bus_frame=1, bus_wdata is stored at location bus_addr[6:0].
- R3: A read cycle has two clocks. The first rising edge with bus_rd=1 and bus_frame=1 captures bus_addr[6:0]. Throughout the second clock, bus_rdata holds the word stored at that captured location.
- R4: Writing 0x000A, 0x000B, 0x000C and 0x000D to locations 0 to 3 and then reading locations 0 to 3 returns them in that same order. No read returns the word of the previous access.
- R5: During the first clock of a read, bus_rdata already shows the word at the live bus_addr[6:0].
- R6: bus_rdata_oe is 1 exactly while bus_rd=1 and bus_frame=1. Otherwise it is 0 and bus_rdata is 0.
- R7: Address bits 11 to 7 are ignored. Addresses 0x085 and 0x005 reach the same word, and so do 0xF7F and 0x07F.
- R8: With bus_frame=0, a write strobe changes no location and a read strobe neither enables the output nor starts a read phase.
- R9: A write cycle followed immediately, with no idle clock, by a read of the same address returns the newly written word.
- R10: Stopping the bus clock between transactions, for any length of time, loses no stored word and does not disturb the next read.
- R11: While bus_rd is held high across consecutive read cycles, each two-clock cycle returns the word of its own address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Host-supplied bus clock; runs only during transactions |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe, active high |
| bus_rd | input | 1 | Read strobe, active high |
| bus_frame | input | 1 | Transaction qualifier, active high |
| bus_addr | input | 12 | Word address; only bits 6:0 are decoded |
| bus_wdata | input | 16 | Write data from the host |
| bus_rdata | output | 16 | Read data toward the pad |
| bus_rdata_oe | output | 1 | Output enable for the read-data pad driver |

## Verification
The properties take for granted that the host holds bus_addr steady across both clocks of a read. They also assume the host never raises write and read together, and that it gives each read exactly two edges, which is why the read-phase flag is expected to alternate. The stimulus changes inputs only at falling edges and keeps every read two clocks long, including when the read strobe stays high across cycles. It pauses the clock only at a falling edge between transactions, so the clock always stops low and no partial edge is seen.

// File: rtl/hsb_pkg.sv
package hsb_pkg;
    parameter int ADDR_W = 12;
    parameter int DATA_W = 16;
    parameter int IDX_W  = 7;
    localparam int DEPTH = 1 << IDX_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wr_port_t;

    typedef struct packed {
        logic active;
        idx_t idx;
    } rd_req_t;

    function automatic idx_t to_idx(input addr_t a);
        return a[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/hsb_wr_capture.sv
module hsb_wr_capture
    import hsb_pkg::*;
(
    input  logic     wr,
    input  logic     frame,
    input  addr_t    addr,
    input  word_t    wdata,
    output wr_port_t wport
);
    always_comb begin
        wport.en   = wr & frame;
        wport.idx  = to_idx(addr);
        wport.data = wdata;
    end
endmodule

// File: rtl/hsb_rd_track.sv
module hsb_rd_track
    import hsb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd,
    input  logic frame,
    input  addr_t addr,
    output logic  second,
    output idx_t  cap_idx,
    output rd_req_t req
);
    logic active;
    assign active = rd & frame;

    always_ff @(posedge clk) begin
        if (rst) begin
            second  <= 1'b0;
            cap_idx <= '0;
        end else if (active) begin
            if (!second) begin
                second  <= 1'b1;
                cap_idx <= to_idx(addr);
            end else begin
                second  <= 1'b0;
            end
        end else begin
            second <= 1'b0;
        end
    end

    always_comb begin
        req.active = active;
        req.idx    = second ? cap_idx : to_idx(addr);
    end
endmodule

// File: rtl/hsb_regfile.sv
module hsb_regfile
    import hsb_pkg::*;
(
    input  logic     clk,
    input  wr_port_t wport,
    input  idx_t     ridx,
    output word_t    rword
);
    word_t words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (wport.en && wport.idx == idx_t'(g)) begin
                words[g] <= wport.data;
            end
        end
    end

    assign rword = words[ridx];
endmodule

// File: rtl/hsb_sram_slave.sv
module hsb_sram_slave
    import hsb_pkg::*;
(
    input  logic              bus_clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_frame,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rdata_oe
);
    wr_port_t wport;
    rd_req_t  rreq;
    logic     rd_second;
    idx_t     rd_cap_idx;
    word_t    mem_word;
    logic     unused_hi_addr;

    assign unused_hi_addr = ^bus_addr[ADDR_W-1:IDX_W];

    hsb_wr_capture u_wr (
        .wr    (bus_wr),
        .frame (bus_frame),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .wport (wport)
    );

    hsb_rd_track u_rd (
        .clk     (bus_clk),
        .rst     (rst),
        .rd      (bus_rd),
        .frame   (bus_frame),
        .addr    (bus_addr),
        .second  (rd_second),
        .cap_idx (rd_cap_idx),
        .req     (rreq)
    );

    hsb_regfile u_mem (
        .clk   (bus_clk),
        .wport (wport),
        .ridx  (rreq.idx),
        .rword (mem_word)
    );

    assign bus_rdata_oe = rreq.active;
    assign bus_rdata    = rreq.active ? mem_word : '0;
endmodule

// File: rtl/hsb_sram_slave_chk.sv
module hsb_sram_slave_chk
    import hsb_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  rd,
    input logic  frame,
    input addr_t addr,
    input word_t rdata,
    input logic  oe,
    input logic  second,
    input idx_t  cap_idx
);
    // R1
    rst_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !second);

    // R6
    oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd && frame) |-> (!oe && rdata == '0));

    // R3
    phase_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && frame && !second) |=> second);

    // R3
    addr_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && frame && !second) |=> (cap_idx == $past(addr[IDX_W-1:0])));

    // R11
    phase_clear_chk: assert property (@(posedge clk) disable iff (rst)
        second |=> !second);

    // R8
    frame_low_chk: assert property (@(posedge clk) disable iff (rst)
        !frame |=> !second);
endmodule

bind hsb_sram_slave hsb_sram_slave_chk u_chk (
    .clk     (bus_clk),
    .rst     (rst),
    .rd      (bus_rd),
    .frame   (bus_frame),
    .addr    (bus_addr),
    .rdata   (bus_rdata),
    .oe      (bus_rdata_oe),
    .second  (rd_second),
    .cap_idx (rd_cap_idx)
);

// File: tb/hsb_sram_slave_test.sv
module hsb_sram_slave_test;
    import hsb_pkg::*;

    typedef struct packed {
        logic        is_wr;
        logic [11:0] addr;
        logic [15:0] data;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 12'h000, 16'h000A},
        '{1'b1, 12'h001, 16'h000B},
        '{1'b1, 12'h002, 16'h000C},
        '{1'b1, 12'h003, 16'h000D},
        '{1'b0, 12'h000, 16'h000A},
        '{1'b0, 12'h001, 16'h000B},
        '{1'b0, 12'h002, 16'h000C},
        '{1'b0, 12'h003, 16'h000D},
        '{1'b1, 12'h07F, 16'hBEEF},
        '{1'b1, 12'h040, 16'h1234},
        '{1'b0, 12'h07F, 16'hBEEF},
        '{1'b0, 12'h040, 16'h1234},
        '{1'b1, 12'h003, 16'h5555},
        '{1'b0, 12'h003, 16'h5555}
    };

    logic        clk = 1'b0;
    logic        clk_run = 1'b1;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic        frame = 1'b0;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        oe;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always begin
        #2.5;
        if (clk_run) clk = ~clk;
    end

    hsb_sram_slave uut (
        .bus_clk      (clk),
        .rst          (rst),
        .bus_wr       (wr),
        .bus_rd       (rd),
        .bus_frame    (frame),
        .bus_addr     (addr),
        .bus_wdata    (wdata),
        .bus_rdata    (rdata),
        .bus_rdata_oe (oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns one clock later at the next falling edge.
    task automatic do_write(input logic [11:0] a, input logic [15:0] d, input logic f);
        wr = 1'b1; rd = 1'b0; frame = f; addr = a; wdata = d;
        @(negedge clk);
    endtask

    // Called at a falling edge; two clocks; samples in both.
    task automatic do_read(input logic [11:0] a, input logic [15:0] exp, input string tag);
        wr = 1'b0; rd = 1'b1; frame = 1'b1; addr = a;
        #1;
        chk(oe == 1'b1, "R6 oe in first clock", 16'(oe), 16'h1);
        chk(rdata == exp, "R5 first-clock data", rdata, exp);
        @(negedge clk);
        chk(rdata == exp, tag, rdata, exp);
        @(negedge clk);
    endtask

    task automatic do_idle(input int n);
        wr = 1'b0; rd = 1'b0; frame = 1'b0;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: output enable low after reset
        chk(oe == 1'b0, "R1 oe after reset", 16'(oe), 16'h0);
        chk(rdata == 16'h0, "R1 rdata after reset", rdata, 16'h0);

        // R2 R3 R4: table walk
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].is_wr) do_write(VECS[i].addr, VECS[i].data, 1'b1);
            else do_read(VECS[i].addr, VECS[i].data, "R4 R3 R2 table read");
            do_idle(1);
            // R6: enable drops after read
            chk(oe == 1'b0, "R6 oe idle", 16'(oe), 16'h0);
        end

        // R7: high address bits alias
        do_write(12'h085, 16'h7777, 1'b1);
        do_idle(1);
        do_read(12'h005, 16'h7777, "R7 alias 0x085");
        do_write(12'hF7F, 16'h9999, 1'b1);
        do_idle(1);
        do_read(12'h07F, 16'h9999, "R7 alias 0xF7F");
        do_idle(1);

        // R8: frame low blocks write and read
        do_write(12'h009, 16'hAAAA, 1'b1);
        do_write(12'h009, 16'h3333, 1'b0);
        wr = 1'b0; rd = 1'b1; frame = 1'b0; addr = 12'h009;
        #1;
        chk(oe == 1'b0, "R8 oe with frame low", 16'(oe), 16'h0);
        @(negedge clk);
        do_idle(1);
        do_read(12'h009, 16'hAAAA, "R8 write ignored");

        // R9: write then read same address with no idle clock
        do_write(12'h014, 16'h4242, 1'b1);
        do_read(12'h014, 16'h4242, "R9 write-read back to back");
        do_idle(1);

        // R10: clock gated off between transactions
        do_write(12'h01E, 16'h6161, 1'b1);
        do_idle(1);
        clk_run = 1'b0;
        #200;
        clk_run = 1'b1;
        @(negedge clk);
        do_read(12'h01E, 16'h6161, "R10 after clock pause");
        do_idle(1);
        clk_run = 1'b0;
        #97;
        clk_run = 1'b1;
        @(negedge clk);
        do_read(12'h000, 16'h000A, "R10 older word after pause");

        // R11: read strobe held across consecutive reads
        do_read(12'h001, 16'h000B, "R11 consecutive read 1");
        do_read(12'h07F, 16'h9999, "R11 consecutive read 2");
        do_read(12'h040, 16'h1234, "R11 consecutive read 3");
        do_idle(1);
        chk(oe == 1'b0, "R6 oe after burst", 16'(oe), 16'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule